// File: doc/BRIEF.md
# Receive Frame Queue with Word Readout

The block buffers received Ethernet frames in a circular set of frame slots and lets a host drain them one 32-bit word at a time through a single data register. Bytes arrive on a simple stream with start and end markers. For each accepted frame the block stores a 16-bit length field, then the frame bytes, then a CRC-32 computed over those bytes. The last word is padded with zeros, and the stored frame is presented as little-endian words.

A small register port gives the host four registers: an event register, a control register, the data register and a count of pending frames. The receive event bit drives an interrupt line. When software reads the word that holds a frame's final stored byte, the block moves on to the next slot, so the host never moves a pointer itself. A frame that arrives while reception is off, while the ring is full, or that is longer than the slot allows is discarded whole.

Top module: `rxq_frame_queue`

## Requirements
- R1: The ring holds at most SLOTS (default 31) frames. A frame whose start byte arrives while SLOTS frames are pending is discarded, and the count stays at SLOTS.
- R2: A frame is stored only if control bit 0 (enable) is set when its start byte is taken. The control register is at address 1, resets to 0 and reads back what was written.
- R3: The first stored word holds the frame size plus 6 in bits 15:0 and the first two frame bytes in bits 23:16 and 31:24.
- R4: Frame bytes are packed little-endian from stored byte 2 onward. The next four bytes are the CRC-32 of the frame bytes, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an all-ones preset and a final inversion.
- R5: Stored bytes beyond the CRC in the last word of a frame read as zero.
- R6: Each read of the data register (address 2) returns the next stored word. The read after which no stored byte of the frame remains moves to the next slot, wrapping modulo SLOTS, and lowers the pending count by one.
- R7: Storing a frame sets bit 0 of the event register (address 0) and raises irq. Writing 1 to that bit clears it, and a store in the same cycle wins.
- R8: A control write with bit 4 set clears the pending count and any partly read frame, and abandons a frame still being received.
- R9: Address 3 reads the number of pending frames.
- R10: A data read with no pending frame returns zero and leaves the readout position unchanged.
- R11: rx_ready is high when reception is disabled or fewer than SLOTS frames are pending. It is low during the cycles that append the CRC and the header after a frame's last byte.
- R12: A frame longer than MAX_FRAME (default 64) bytes is discarded. A frame of exactly MAX_FRAME bytes is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_first | input | 1 | Byte is the first of a frame |
| rx_last | input | 1 | Byte is the last of a frame |
| rx_ready | output | 1 | Source may present bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata the next cycle |
| reg_addr | input | 2 | Register select: 0 event, 1 control, 2 data, 3 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Receive event interrupt |

## Verification
The assertions check on every cycle that the pending count stays within the ring size, that a store never happens into a full ring, and that a flush empties the queue on the next cycle. They also check that a read of an empty queue leaves the readout position alone, that a disabled start never enters reception, that each store raises irq, and that CRC appending always ends in the header write. Only the bench scenarios can show that word contents, CRC values and zero padding are correct for frame sizes that end in each byte lane. The same holds for the slot index wrapping after more than SLOTS frames, for the full-ring and oversize drops, and for a flush in the middle of a readout.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
   localparam int          CTRL_EN_BIT    = 0;
   localparam int          CTRL_FLUSH_BIT = 4;
   localparam int          EVT_RX_BIT     = 0;

   typedef enum logic [1:0] {
      REG_EVENT = 2'd0,
      REG_CTRL  = 2'd1,
      REG_DATA  = 2'd2,
      REG_COUNT = 2'd3
   } reg_sel_e;

   typedef enum logic [2:0] {
      W_IDLE,
      W_BODY,
      W_SKIP,
      W_CRC,
      W_PAD,
      W_HDR
   } wr_state_e;
endpackage

// File: rtl/rxq_crc32.sv
module rxq_crc32 #(
   parameter logic [31:0] POLY = rxq_pkg::CRC_POLY_REFL
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        step,
   input  logic [7:0]  din,
   output logic [31:0] crc_q
);
   logic [31:0] chain [0:8];

   assign chain[0] = (init ? 32'hFFFF_FFFF : crc_q) ^ {24'd0, din};

   generate
      for (genvar b = 0; b < 8; b++) begin : g_bit
         assign chain[b+1] = chain[b][0] ? ((chain[b] >> 1) ^ POLY) : (chain[b] >> 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
      else if (step) crc_q <= chain[8];
   end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int SLOTS  = 31,
   parameter int WPS    = 18,
   parameter int LENW   = 7,
   parameter int SLOT_W = $clog2(SLOTS),
   parameter int WORD_W = $clog2(WPS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [SLOT_W-1:0] wslot,
   input  logic [WORD_W-1:0] wword,
   input  logic [31:0]       wdata,
   input  logic              len_we,
   input  logic [LENW-1:0]   len_val,
   input  logic [SLOT_W-1:0] rslot,
   input  logic [WORD_W-1:0] rword,
   output logic [31:0]       rdata,
   output logic [LENW-1:0]   rlen
);
   localparam int DEPTH = SLOTS * WPS;
   localparam int AW    = $clog2(DEPTH);

   logic [31:0]     mem     [DEPTH];
   logic [LENW-1:0] len_tab [SLOTS];
   logic [AW-1:0]   waddr, raddr;

   assign waddr = AW'(int'(wslot) * WPS + int'(wword));
   assign raddr = AW'(int'(rslot) * WPS + int'(rword));

   always_ff @(posedge clk) begin
      if (we)     mem[waddr]     <= wdata;
      if (len_we) len_tab[wslot] <= len_val;
   end

   assign rdata = mem[raddr];
   assign rlen  = len_tab[rslot];

   assert_write_in_range_R1: assert property (@(posedge clk)
      we |-> (int'(wslot) < SLOTS && int'(wword) < WPS));
endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
   import rxq_pkg::*;
#(
   parameter int SLOTS     = 31,
   parameter int MAX_FRAME = 64,
   parameter int WPS       = 18,
   parameter int LENW      = 7,
   parameter int SLOT_W    = $clog2(SLOTS),
   parameter int WORD_W    = $clog2(WPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_first,
   input  logic              rx_last,
   input  logic              enable,
   input  logic              flush,
   input  logic              full,
   input  logic [SLOT_W-1:0] wr_slot,
   output logic              busy,
   output logic              mem_we,
   output logic [SLOT_W-1:0] mem_slot,
   output logic [WORD_W-1:0] mem_word,
   output logic [31:0]       mem_wdata,
   output logic              commit,
   output logic [LENW-1:0]   commit_len
);
   localparam int POS_W = LENW;

   wr_state_e         state_q;
   logic [POS_W-1:0]  pos_q, pos_cur;
   logic [LENW-1:0]   fsize_q;
   logic [31:0]       acc_q;
   logic [15:0]       w0_q;
   logic [1:0]        crc_idx_q;
   logic [SLOT_W-1:0] slot_q;
   logic [31:0]       crc_q, crc_fin;
   logic              push, start_ok, oversize, crc_step, crc_init;
   logic [7:0]        pbyte;
   logic [1:0]        lane;
   logic [WORD_W-1:0] widx;

   rxq_crc32 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .step  (crc_step),
      .din   (pbyte),
      .crc_q (crc_q)
   );

   assign crc_fin  = ~crc_q;
   assign start_ok = (state_q == W_IDLE) && rx_valid && rx_first && enable && !full && !flush;
   assign oversize = (fsize_q == LENW'(MAX_FRAME));

   always_comb begin
      push    = 1'b0;
      pbyte   = rx_data;
      pos_cur = pos_q;
      unique case (state_q)
         W_IDLE: begin
            push    = start_ok;
            pos_cur = POS_W'(2);
         end
         W_BODY: push = rx_valid && !oversize && !flush;
         W_CRC: begin
            push  = !flush;
            pbyte = crc_fin[8*crc_idx_q +: 8];
         end
         default: ;
      endcase
   end

   assign lane     = pos_cur[1:0];
   assign widx     = WORD_W'(pos_cur >> 2);
   assign crc_init = (state_q == W_IDLE);
   assign crc_step = push && (state_q == W_IDLE || state_q == W_BODY);
   assign busy     = (state_q == W_CRC) || (state_q == W_PAD) || (state_q == W_HDR);

   assign commit_len = fsize_q + LENW'(6);
   assign commit     = (state_q == W_HDR) && !flush;
   assign mem_slot   = slot_q;

   always_comb begin
      mem_we    = 1'b0;
      mem_word  = widx;
      mem_wdata = {pbyte, acc_q[23:0]};
      if (push && widx != '0 && lane == 2'd3) begin
         mem_we = 1'b1;
      end else if (state_q == W_PAD && !flush) begin
         mem_we    = 1'b1;
         mem_wdata = acc_q;
      end else if (state_q == W_HDR && !flush) begin
         mem_we    = 1'b1;
         mem_word  = '0;
         mem_wdata = {w0_q, {(16-LENW){1'b0}}, commit_len};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= W_IDLE;
         pos_q     <= '0;
         fsize_q   <= '0;
         acc_q     <= '0;
         w0_q      <= '0;
         crc_idx_q <= '0;
         slot_q    <= '0;
      end else begin
         if (push) begin
            pos_q <= pos_cur + POS_W'(1);
            if (widx == '0) begin
               if (lane == 2'd2) w0_q[7:0]  <= pbyte;
               else              w0_q[15:8] <= pbyte;
            end else if (lane == 2'd3) begin
               acc_q <= '0;
            end else begin
               acc_q[8*lane +: 8] <= pbyte;
            end
         end
         if (flush) begin
            state_q <= W_IDLE;
            acc_q   <= '0;
         end else begin
            unique case (state_q)
               W_IDLE: if (rx_valid && rx_first) begin
                  if (start_ok) begin
                     slot_q    <= wr_slot;
                     fsize_q   <= LENW'(1);
                     crc_idx_q <= '0;
                     state_q   <= rx_last ? W_CRC : W_BODY;
                  end else if (!rx_last) begin
                     state_q <= W_SKIP;
                  end
               end
               W_BODY: if (rx_valid) begin
                  if (oversize) begin
                     state_q <= rx_last ? W_IDLE : W_SKIP;
                     acc_q   <= '0;
                  end else begin
                     fsize_q <= fsize_q + LENW'(1);
                     if (rx_last) state_q <= W_CRC;
                  end
               end
               W_SKIP: if (rx_valid && rx_last) state_q <= W_IDLE;
               W_CRC: begin
                  crc_idx_q <= crc_idx_q + 2'd1;
                  if (crc_idx_q == 2'd3) state_q <= (lane == 2'd3) ? W_HDR : W_PAD;
               end
               W_PAD: begin
                  state_q <= W_HDR;
                  acc_q   <= '0;
               end
               W_HDR:   state_q <= W_IDLE;
               default: state_q <= W_IDLE;
            endcase
         end
      end
   end

   assert_disabled_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == W_IDLE && rx_valid && rx_first && !enable) |=> (state_q != W_BODY && state_q != W_CRC));

   assert_crc_then_header_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == W_CRC && crc_idx_q == 2'd3 && !flush) |=> (state_q == W_PAD || state_q == W_HDR));

   assert_stored_len_bounds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (int'(commit_len) >= 7 && int'(commit_len) <= MAX_FRAME + 6));
endmodule

// File: rtl/rxq_reader.sv
module rxq_reader #(
   parameter int SLOTS  = 31,
   parameter int WPS    = 18,
   parameter int LENW   = 7,
   parameter int SLOT_W = $clog2(SLOTS),
   parameter int WORD_W = $clog2(WPS),
   parameter int CNT_W  = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop_req,
   input  logic              flush,
   input  logic              commit,
   input  logic [LENW-1:0]   slot_len,
   output logic [SLOT_W-1:0] rd_slot,
   output logic [WORD_W-1:0] rd_word,
   output logic [CNT_W-1:0]  pending,
   output logic [SLOT_W-1:0] wr_slot,
   output logic              has_frame
);
   logic [LENW-1:0]   rem_q, rem_cur;
   logic              pop, last, dec;
   logic [SLOT_W:0]   slot_sum;

   assign has_frame = (pending != '0);
   assign pop       = pop_req && has_frame && !flush;
   assign rem_cur   = (rd_word == '0) ? slot_len : rem_q;
   assign last      = (rem_cur <= LENW'(4));
   assign dec       = pop && last;

   assign slot_sum = (SLOT_W+1)'(rd_slot) + (SLOT_W+1)'(pending);
   assign wr_slot  = (slot_sum >= (SLOT_W+1)'(SLOTS)) ? SLOT_W'(slot_sum - (SLOT_W+1)'(SLOTS))
                                                      : SLOT_W'(slot_sum);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_slot <= '0;
         rd_word <= '0;
         rem_q   <= '0;
         pending <= '0;
      end else if (flush) begin
         rd_word <= '0;
         rem_q   <= '0;
         pending <= '0;
      end else begin
         unique case ({commit, dec})
            2'b10:   pending <= pending + CNT_W'(1);
            2'b01:   pending <= pending - CNT_W'(1);
            default: ;
         endcase
         if (pop) begin
            if (last) begin
               rd_word <= '0;
               rd_slot <= (rd_slot == SLOT_W'(SLOTS - 1)) ? '0 : rd_slot + SLOT_W'(1);
            end else begin
               rd_word <= rd_word + WORD_W'(1);
               rem_q   <= rem_cur - LENW'(4);
            end
         end
      end
   end

   assert_pending_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pending) <= SLOTS);

   assert_no_store_into_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> int'(pending) < SLOTS);

   assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (pending == '0 && rd_word == '0));

   assert_empty_read_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !has_frame && !flush) |=> ($stable(rd_slot) && $stable(rd_word)));

   assert_slot_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_slot) < SLOTS);
endmodule

// File: rtl/rxq_frame_queue.sv
module rxq_frame_queue
   import rxq_pkg::*;
#(
   parameter int SLOTS     = 31,
   parameter int MAX_FRAME = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   input  logic        rx_first,
   input  logic        rx_last,
   output logic        rx_ready,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq
);
   localparam int WPS    = (MAX_FRAME + 6 + 3) / 4;
   localparam int LENW   = $clog2(MAX_FRAME + 7);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int WORD_W = $clog2(WPS);
   localparam int CNT_W  = $clog2(SLOTS + 1);

   generate
      if (SLOTS < 2 || SLOTS > 255) begin : g_bad_slots
         $error("rxq_frame_queue: SLOTS out of range");
      end
      if (MAX_FRAME < 2 || LENW >= 16) begin : g_bad_frame
         $error("rxq_frame_queue: MAX_FRAME out of range");
      end
   endgenerate

   logic [31:0]       ctrl_q;
   logic              evt_q;
   logic              flush, busy, full, commit, has_frame, mem_we, pop_req;
   logic [LENW-1:0]   commit_len, slot_len;
   logic [SLOT_W-1:0] wr_slot, rd_slot, mem_slot;
   logic [WORD_W-1:0] rd_word, mem_word;
   logic [CNT_W-1:0]  pending;
   logic [31:0]       mem_wdata, store_rdata;

   assign flush   = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[CTRL_FLUSH_BIT];
   assign pop_req = reg_rd && (reg_addr == REG_DATA);
   assign full    = (pending == CNT_W'(SLOTS));

   rxq_writer #(
      .SLOTS(SLOTS), .MAX_FRAME(MAX_FRAME), .WPS(WPS), .LENW(LENW),
      .SLOT_W(SLOT_W), .WORD_W(WORD_W)
   ) u_writer (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_first   (rx_first),
      .rx_last    (rx_last),
      .enable     (ctrl_q[CTRL_EN_BIT]),
      .flush      (flush),
      .full       (full),
      .wr_slot    (wr_slot),
      .busy       (busy),
      .mem_we     (mem_we),
      .mem_slot   (mem_slot),
      .mem_word   (mem_word),
      .mem_wdata  (mem_wdata),
      .commit     (commit),
      .commit_len (commit_len)
   );

   rxq_store #(
      .SLOTS(SLOTS), .WPS(WPS), .LENW(LENW), .SLOT_W(SLOT_W), .WORD_W(WORD_W)
   ) u_store (
      .clk     (clk),
      .we      (mem_we),
      .wslot   (mem_slot),
      .wword   (mem_word),
      .wdata   (mem_wdata),
      .len_we  (commit),
      .len_val (commit_len),
      .rslot   (rd_slot),
      .rword   (rd_word),
      .rdata   (store_rdata),
      .rlen    (slot_len)
   );

   rxq_reader #(
      .SLOTS(SLOTS), .WPS(WPS), .LENW(LENW), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
   ) u_reader (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop_req   (pop_req),
      .flush     (flush),
      .commit    (commit),
      .slot_len  (slot_len),
      .rd_slot   (rd_slot),
      .rd_word   (rd_word),
      .pending   (pending),
      .wr_slot   (wr_slot),
      .has_frame (has_frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         evt_q  <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == REG_CTRL) ctrl_q <= reg_wdata;
         if (commit)
            evt_q <= 1'b1;
         else if (reg_wr && reg_addr == REG_EVENT && reg_wdata[EVT_RX_BIT])
            evt_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         unique case (reg_addr)
            REG_EVENT: reg_rdata <= {31'd0, evt_q};
            REG_CTRL:  reg_rdata <= ctrl_q;
            REG_DATA:  reg_rdata <= has_frame ? store_rdata : 32'd0;
            REG_COUNT: reg_rdata <= 32'(pending);
            default:   reg_rdata <= '0;
         endcase
      end
   end

   assign rx_ready = !busy && (!ctrl_q[CTRL_EN_BIT] || !full);
   assign irq      = evt_q;

   assert_irq_on_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> irq);
endmodule

// File: tb/tb_rxq_frame_queue.sv
`timescale 1ns/1ps
module tb_rxq_frame_queue;
   localparam int SLOTS = 31;
   localparam int MAXF  = 64;
   localparam logic [1:0] A_EVT = 2'd0, A_CTRL = 2'd1, A_DATA = 2'd2, A_CNT = 2'd3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, rx_valid, rx_first, rx_last, rx_ready, reg_wr, reg_rd, irq;
   logic [7:0]  rx_data;
   logic [1:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;

   rxq_frame_queue #(.SLOTS(SLOTS), .MAX_FRAME(MAXF)) dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_first(rx_first), .rx_last(rx_last), .rx_ready(rx_ready),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   int n_chk = 0, n_fail = 0, model_pend = 0;
   bit done = 0;
   logic [31:0] exp_words[$];
   int          exp_nw[$];
   logic [7:0]  fb [0:127];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   function automatic logic [31:0] ref_crc(input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic fbk;
            fbk = c[0] ^ fb[i][b];
            c = c >> 1;
            if (fbk) c = c ^ 32'hEDB88320;
         end
      end
      return ~c;
   endfunction

   task automatic host_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic host_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   // driver: sends a frame and pushes its expected stored words
   task automatic send_frame(input int size, input int seed, input bit store, input bit force_send);
      for (int i = 0; i < size; i++) fb[i] = 8'((seed * 7 + i * 13 + 5) & 8'hFF);
      for (int i = 0; i < size; i++) begin
         @(negedge clk);
         if (!force_send) while (!rx_ready) @(negedge clk);
         rx_valid = 1'b1; rx_data = fb[i];
         rx_first = (i == 0); rx_last = (i == size - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
      if (store) begin
         logic [7:0]  sb [0:135];
         logic [31:0] c;
         int tot, nw;
         check(rx_ready == 1'b0, "R11 busy after last byte", 32'(rx_ready), 32'd0);
         c = ref_crc(size);
         tot = size + 6;
         nw = (tot + 3) / 4;
         for (int k = 0; k < nw * 4; k++) sb[k] = 8'd0;
         sb[0] = tot[7:0]; sb[1] = tot[15:8];
         for (int k = 0; k < size; k++) sb[2 + k] = fb[k];
         for (int j = 0; j < 4; j++) sb[2 + size + j] = c[8*j +: 8];
         for (int w = 0; w < nw; w++)
            exp_words.push_back({sb[4*w+3], sb[4*w+2], sb[4*w+1], sb[4*w]});
         exp_nw.push_back(nw);
         model_pend++;
      end
      repeat (10) @(negedge clk);
   endtask

   // monitor: reads one frame and compares against the scoreboard
   task automatic drain_one();
      logic [31:0] d, e;
      int nw;
      nw = exp_nw.pop_front();
      for (int w = 0; w < nw; w++) begin
         host_read(A_DATA, d);
         e = exp_words.pop_front();
         if (w == 0)           check(d === e, "R3 header word", d, e);
         else if (w == nw - 1) check(d === e, "R5 last word", d, e);
         else                  check(d === e, "R4 body word", d, e);
      end
      model_pend--;
      host_read(A_CNT, d);
      check(d == 32'(model_pend), "R6 count after frame", d, 32'(model_pend));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_first = 1'b0; rx_last = 1'b0;
      reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rx_ready == 1'b1, "R11 reset ready", 32'(rx_ready), 32'd1);
      check(irq == 1'b0, "R7 reset irq", 32'(irq), 32'd0);
      host_read(A_CNT, d);  check(d == 0, "R9 reset count", d, 0);
      host_read(A_EVT, d);  check(d == 0, "R7 reset event", d, 0);
      host_read(A_CTRL, d); check(d == 0, "R2 reset ctrl", d, 0);

      // R2: disabled reception drops frame
      send_frame(6, 1, 0, 0);
      host_read(A_CNT, d); check(d == 0, "R2 disabled drop", d, 0);
      check(irq == 1'b0, "R2 no irq when disabled", 32'(irq), 32'd0);

      host_write(A_CTRL, 32'h1);
      host_read(A_CTRL, d); check(d == 32'h1, "R2 ctrl readback", d, 32'h1);

      // several sizes covering every last-word lane
      send_frame(1, 2, 1, 0);
      send_frame(2, 3, 1, 0);
      send_frame(3, 4, 1, 0);
      send_frame(4, 5, 1, 0);
      send_frame(5, 6, 1, 0);
      send_frame(13, 7, 1, 0);
      host_read(A_CNT, d); check(d == 6, "R9 count six", d, 6);
      host_read(A_EVT, d); check(d == 1, "R7 event set", d, 1);
      check(irq == 1'b1, "R7 irq high", 32'(irq), 32'd1);
      host_write(A_EVT, 32'h1);
      host_read(A_EVT, d); check(d == 0, "R7 event cleared", d, 0);
      check(irq == 1'b0, "R7 irq low", 32'(irq), 32'd0);
      for (int f = 0; f < 6; f++) drain_one();

      // R10: empty read
      host_read(A_DATA, d); check(d == 0, "R10 empty read zero", d, 0);
      host_read(A_CNT, d);  check(d == 0, "R10 count unchanged", d, 0);
      send_frame(7, 8, 1, 0);
      drain_one();

      // R12: length limit
      send_frame(MAXF + 1, 9, 0, 0);
      host_read(A_CNT, d); check(d == 0, "R12 oversize dropped", d, 0);
      send_frame(MAXF, 10, 1, 0);
      host_read(A_CNT, d); check(d == 1, "R12 max size kept", d, 1);
      drain_one();

      // R1: fill the ring, then overflow
      for (int f = 0; f < SLOTS; f++) send_frame((f % 7) + 1, 20 + f, 1, 0);
      host_read(A_CNT, d); check(d == SLOTS, "R1 ring full", d, SLOTS);
      check(rx_ready == 1'b0, "R11 ready low when full", 32'(rx_ready), 32'd0);
      send_frame(4, 99, 0, 1);
      host_read(A_CNT, d); check(d == SLOTS, "R1 overflow dropped", d, SLOTS);
      host_write(A_CTRL, 32'h0);
      check(rx_ready == 1'b1, "R11 ready when disabled", 32'(rx_ready), 32'd1);
      host_write(A_CTRL, 32'h1);
      for (int f = 0; f < SLOTS; f++) drain_one();   // R6 slot index wraps

      // R8: flush in the middle of a readout
      send_frame(10, 40, 1, 0);
      send_frame(5, 41, 1, 0);
      host_read(A_DATA, d); check(d === exp_words[0], "R3 first word before flush", d, exp_words[0]);
      host_write(A_CTRL, 32'h11);
      host_read(A_CNT, d); check(d == 0, "R8 flush clears count", d, 0);
      exp_words.delete(); exp_nw.delete(); model_pend = 0;
      send_frame(3, 42, 1, 0);
      host_read(A_CNT, d); check(d == 1, "R8 store after flush", d, 1);
      drain_one();

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule